// File: doc/BRIEF.md
# Chained Descriptor Memory-Copy Engine

This block is a single-channel memory-to-memory copy engine. Software builds a list of transfer descriptors in a small on-chip descriptor RAM and writes the address of the first descriptor into a parameter word. It then issues a start command. The engine walks the list one descriptor at a time. For each valid descriptor it moves the requested number of bytes from a source region to a destination region over a word-wide memory port with a request/acknowledge handshake. It then writes the descriptor's control word back with the valid flag cleared.

Per-descriptor flags decide whether a buffer-done event is raised and whether the walk ends. Four sticky status bits record buffer done, chain done, no valid descriptor and bad descriptor address. Software clears them by writing ones to them. An interrupt output is the OR of the status bits that the mask register enables. The function-code bytes in each descriptor are kept and written back, but they have no effect on the memory port.

The chain controller has seven states:
- `CH_IDLE` goes to `CH_PTR` on start.
- `CH_PTR` loads the first descriptor address and goes to `CH_CHECK`.
- `CH_CHECK` goes to `CH_FETCH` when the address is in the window, or back to `CH_IDLE` with the error bit set.
- `CH_FETCH` reads four words and goes to `CH_EVAL`.
- `CH_EVAL` goes to `CH_COPY` when the valid flag is set, or back to `CH_IDLE` with the no-valid bit set.
- `CH_COPY` goes to `CH_WBACK` when the copy finishes.
- `CH_WBACK` goes to `CH_IDLE` when the last flag is set, or to `CH_CHECK` at the next descriptor.

The copy unit has four states:
- `CP_IDLE` goes to `CP_READ`, or straight to `CP_DONE` for a zero count.
- `CP_READ` goes to `CP_WRITE` on acknowledge.
- `CP_WRITE` goes to `CP_READ` on acknowledge, or to `CP_DONE` once the bytes are used up.
- `CP_DONE` goes back to `CP_IDLE`.

Top module: `dma_chain_top`

## Requirements
- R1: After reset `busy`, `irq` and `mem_req` are low, and the status (register 1) and mask (register 2) both read zero.
- R2: The first descriptor address is bits [31:16] of descriptor-RAM word `PARAM_WORD`. A descriptor at byte address A occupies words (A-DESC_BASE)/4 to +3. Word 0 is {control[31:16], destination code[15:8], source code[7:0]}. Word 1 is the byte count, word 2 the source address and word 3 the destination address.
- R3: A copy of N bytes makes ceil(N/4) read-then-write pairs. Source and destination addresses have their low two bits cleared and step by 4. The first byte sits in lane [31:24] (enable bit 3). The last write enables 1000, 1100 or 1110 for N mod 4 equal to 1, 2 or 3, and 1111 otherwise. All earlier writes enable 1111.
- R4: A byte count of zero completes the descriptor with no memory request.
- R5: If control bit 15 (valid) is clear, status bit 2 is set and the run stops. No memory access is made and the descriptor is left unchanged.
- R6: After each copy, word 0 of the descriptor is rewritten with bit 15 cleared. All other control bits and both code bytes keep their values.
- R7: Control bit 12 set causes status bit 0 to be set after that descriptor's copy. Control bit 12 clear leaves status bit 0 untouched.
- R8: Control bit 11 set causes status bit 1 to be set and the run to stop. Otherwise the next descriptor is fetched at the current address plus 16.
- R9: A descriptor address that is below `DESC_BASE`, not a multiple of 4, or more than window size minus 16 above `DESC_BASE` sets status bit 3. The run then stops with no memory access.
- R10: `irq` is high exactly when the status AND the mask is nonzero, and it follows changes of either.
- R11: Writing register 1 clears the status bits written as one. A bit set by the engine in the same cycle stays set.
- R12: Writing 1 to bit 0 of register 0 while idle starts a run. `busy` is high from the next cycle until the run stops, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ram_we | input | 1 | Host write strobe for descriptor RAM |
| host_ram_idx | input | IDX_W | Host word index into descriptor RAM |
| host_ram_wdata | input | 32 | Host write data for descriptor RAM |
| host_ram_rdata | output | 32 | Descriptor RAM word at `host_ram_idx` |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command/busy, 1 status, 2 mask |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data |
| busy | output | 1 | A run is in progress |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |

## Verification
The assertions assume the memory side raises `mem_ack` only while `mem_req` is high, and for a single cycle per access. They also assume the host leaves the descriptor RAM alone while `busy` is high. The bench's memory model answers each request one cycle after it appears and drops acknowledge for a cycle between accesses. Every descriptor and parameter word is loaded only while the engine is idle. All descriptor addresses come from the parameter word or from the engine's own 16-byte step, so the only out-of-window addresses seen are the ones placed there on purpose to exercise the error path.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam int STAT_W   = 4;
    localparam int ST_BUF   = 0;
    localparam int ST_CHAIN = 1;
    localparam int ST_EMPTY = 2;
    localparam int ST_ERR   = 3;

    localparam int CTL_VALID = 15;
    localparam int CTL_INTR  = 12;
    localparam int CTL_LAST  = 11;

    typedef struct packed {
        logic [15:0] ctrl;
        logic [7:0]  dst_fc;
        logic [7:0]  src_fc;
    } desc_head_t;

    typedef enum logic [2:0] {
        CH_IDLE, CH_PTR, CH_CHECK, CH_FETCH, CH_EVAL, CH_COPY, CH_WBACK
    } chain_state_e;

    typedef enum logic [1:0] {
        CP_IDLE, CP_READ, CP_WRITE, CP_DONE
    } copy_state_e;

    function automatic logic [3:0] tail_lanes(input logic [31:0] remain);
        logic [3:0] lanes;
        if (remain >= 32'd4) begin
            lanes = 4'b1111;
        end else begin
            unique case (remain[1:0])
                2'd1:    lanes = 4'b1000;
                2'd2:    lanes = 4'b1100;
                2'd3:    lanes = 4'b1110;
                default: lanes = 4'b1111;
            endcase
        end
        return lanes;
    endfunction

endpackage

// File: rtl/dma_desc_ram.sv
module dma_desc_ram #(
    parameter int WORDS = 64,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             a_we,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [31:0]      a_wdata,
    output logic [31:0]      a_rdata,
    input  logic             b_we,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [31:0]      b_wdata,
    output logic [31:0]      b_rdata
);

    logic [31:0] store [WORDS];

    // Port b (engine) is written last so it wins a same-word collision.
    always_ff @(posedge clk) begin
        if (a_we) store[a_idx] <= a_wdata;
        if (b_we) store[b_idx] <= b_wdata;
    end

    assign a_rdata = store[a_idx];
    assign b_rdata = store[b_idx];

endmodule

// File: rtl/dma_copy_unit.sv
module dma_copy_unit
    import dma_chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [31:0] src_addr,
    input  logic [31:0] dst_addr,
    input  logic [31:0] byte_cnt,
    output logic        done,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack
);

    copy_state_e state, state_n;
    logic [31:0] rd_ptr, wr_ptr, remain, data_q;

    always_comb begin
        state_n = state;
        unique case (state)
            CP_IDLE:  if (go) state_n = (byte_cnt == 32'd0) ? CP_DONE : CP_READ;
            CP_READ:  if (mem_ack) state_n = CP_WRITE;
            CP_WRITE: if (mem_ack) state_n = (remain <= 32'd4) ? CP_DONE : CP_READ;
            CP_DONE:  state_n = CP_IDLE;
            default:  state_n = CP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CP_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        mem_req   = (state == CP_READ) || (state == CP_WRITE);
        mem_we    = (state == CP_WRITE);
        mem_addr  = (state == CP_WRITE) ? wr_ptr : rd_ptr;
        mem_be    = (state == CP_WRITE) ? tail_lanes(remain) : 4'b1111;
        mem_wdata = data_q;
        done      = (state == CP_DONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            remain <= '0;
            data_q <= '0;
        end else begin
            if (state == CP_IDLE && go) begin
                rd_ptr <= src_addr & ~32'd3;
                wr_ptr <= dst_addr & ~32'd3;
                remain <= byte_cnt;
            end
            if (state == CP_READ && mem_ack) begin
                data_q <= mem_rdata;
                rd_ptr <= rd_ptr + 32'd4;
            end
            if (state == CP_WRITE && mem_ack) begin
                wr_ptr <= wr_ptr + 32'd4;
                remain <= (remain > 32'd4) ? remain - 32'd4 : 32'd0;
            end
        end
    end

    // R3: a pending access holds its request, address and direction
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we))
        else $error("request dropped or changed before acknowledge");

    // R3: every write enables at least one lane
    p_write_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_be != 4'b0000)
        else $error("write with no lane enabled");

    // R4: a zero count finishes on the next cycle without touching memory
    p_zero_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CP_IDLE) && go && (byte_cnt == 32'd0) |=> done && !mem_req)
        else $error("zero-length copy accessed memory");

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dma_chain_pkg::*;
#(
    parameter int          RAM_WORDS  = 64,
    parameter int          IDX_W      = $clog2(RAM_WORDS),
    parameter logic [15:0] DESC_BASE  = 16'h0800,
    parameter int          PARAM_WORD = RAM_WORDS - 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] ram_idx,
    input  logic [31:0]      ram_rdata,
    output logic             ram_we,
    output logic [31:0]      ram_wdata,
    output logic             copy_go,
    output logic [31:0]      copy_src,
    output logic [31:0]      copy_dst,
    output logic [31:0]      copy_cnt,
    input  logic             copy_done,
    output logic             ev_buf,
    output logic             ev_chain,
    output logic             ev_empty,
    output logic             ev_err
);

    localparam int          WIN_BYTES = RAM_WORDS * 4;
    localparam logic [15:0] LAST_OK   = 16'(WIN_BYTES - 16);

    chain_state_e state, state_n;
    logic [15:0]      cur_addr;
    logic [15:0]      offset;
    logic             in_window;
    logic [IDX_W-1:0] base_idx;
    logic [1:0]       fidx;
    desc_head_t       head;
    logic [31:0]      cnt_q, src_q, dst_q;

    assign offset    = cur_addr - DESC_BASE;
    assign in_window = (cur_addr >= DESC_BASE) && (offset <= LAST_OK) && (offset[1:0] == 2'b00);
    assign base_idx  = offset[IDX_W+1:2];

    always_comb begin
        state_n = state;
        unique case (state)
            CH_IDLE:  if (start) state_n = CH_PTR;
            CH_PTR:   state_n = CH_CHECK;
            CH_CHECK: state_n = in_window ? CH_FETCH : CH_IDLE;
            CH_FETCH: if (fidx == 2'd3) state_n = CH_EVAL;
            CH_EVAL:  state_n = head.ctrl[CTL_VALID] ? CH_COPY : CH_IDLE;
            CH_COPY:  if (copy_done) state_n = CH_WBACK;
            CH_WBACK: state_n = head.ctrl[CTL_LAST] ? CH_IDLE : CH_CHECK;
            default:  state_n = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        busy      = (state != CH_IDLE);
        ram_idx   = base_idx;
        if (state == CH_PTR)   ram_idx = IDX_W'(PARAM_WORD);
        if (state == CH_FETCH) ram_idx = base_idx + {{(IDX_W-2){1'b0}}, fidx};
        ram_we    = (state == CH_WBACK);
        ram_wdata = {head.ctrl & ~(16'd1 << CTL_VALID), head.dst_fc, head.src_fc};
        copy_go   = (state == CH_EVAL) && head.ctrl[CTL_VALID];
        copy_src  = src_q;
        copy_dst  = dst_q;
        copy_cnt  = cnt_q;
        ev_err    = (state == CH_CHECK) && !in_window;
        ev_empty  = (state == CH_EVAL) && !head.ctrl[CTL_VALID];
        ev_buf    = (state == CH_WBACK) && head.ctrl[CTL_INTR];
        ev_chain  = (state == CH_WBACK) && head.ctrl[CTL_LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            fidx     <= '0;
            head     <= '0;
            cnt_q    <= '0;
            src_q    <= '0;
            dst_q    <= '0;
        end else begin
            unique case (state)
                CH_PTR:   cur_addr <= ram_rdata[31:16];
                CH_CHECK: fidx <= 2'd0;
                CH_FETCH: begin
                    unique case (fidx)
                        2'd0: head  <= desc_head_t'(ram_rdata);
                        2'd1: cnt_q <= ram_rdata;
                        2'd2: src_q <= ram_rdata;
                        default: dst_q <= ram_rdata;
                    endcase
                    fidx <= fidx + 2'd1;
                end
                CH_WBACK: if (!head.ctrl[CTL_LAST]) cur_addr <= cur_addr + 16'd16;
                default: ;
            endcase
        end
    end

    // R12: an idle start makes the engine busy on the next cycle
    p_start_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy)
        else $error("start while idle did not begin a run");

    // R9: a bad descriptor address ends the run
    p_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> !busy)
        else $error("run continued after address error");

    // R5: a descriptor without the valid flag ends the run
    p_empty_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_empty |=> !busy)
        else $error("run continued after empty descriptor");

    // R8: a copy is never launched together with an abort
    p_single_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_err, ev_empty, copy_go}))
        else $error("conflicting descriptor outcomes");

    // R6: a write-back happens only after the copy has reported done
    p_wback_after_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(copy_done))
        else $error("descriptor written back before copy finished");

endmodule

// File: rtl/dma_status_regs.sv
module dma_status_regs
    import dma_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_bits,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              ev_buf,
    input  logic              ev_chain,
    input  logic              ev_empty,
    input  logic              ev_err,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic              irq
);

    logic [STAT_W-1:0] set_bits;
    logic [STAT_W-1:0] clr_eff;

    always_comb begin
        set_bits           = '0;
        set_bits[ST_BUF]   = ev_buf;
        set_bits[ST_CHAIN] = ev_chain;
        set_bits[ST_EMPTY] = ev_empty;
        set_bits[ST_ERR]   = ev_err;
        clr_eff            = clr_we ? clr_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= (status & ~clr_eff) | set_bits;
            if (mask_we) mask <= mask_wdata;
        end
    end

    assign irq = |(status & mask);

    // R11: bits written as one and not set again are gone on the next cycle
    p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (status & $past(clr_bits & ~set_bits)) == '0)
        else $error("status bit survived clear");

    // R7: a buffer-done event is recorded
    p_buf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_buf |=> status[ST_BUF])
        else $error("buffer-done event lost");

    // R10: with everything masked the interrupt stays low
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq)
        else $error("interrupt raised with empty mask");

endmodule

// File: rtl/dma_chain_top.sv
module dma_chain_top
    import dma_chain_pkg::*;
#(
    parameter int          RAM_WORDS  = 64,
    parameter int          IDX_W      = $clog2(RAM_WORDS),
    parameter logic [15:0] DESC_BASE  = 16'h0800,
    parameter int          PARAM_WORD = RAM_WORDS - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ram_we,
    input  logic [IDX_W-1:0]  host_ram_idx,
    input  logic [31:0]       host_ram_wdata,
    output logic [31:0]       host_ram_rdata,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic              busy,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack
);

    logic              start_cmd, clr_we, mask_we;
    logic [IDX_W-1:0]  eng_idx;
    logic [31:0]       eng_rdata, eng_wdata;
    logic              eng_we;
    logic              copy_go, copy_done;
    logic [31:0]       copy_src, copy_dst, copy_cnt;
    logic              ev_buf, ev_chain, ev_empty, ev_err;
    logic [STAT_W-1:0] status, mask;

    assign start_cmd = reg_we && (reg_addr == 2'd0) && reg_wdata[0];
    assign clr_we    = reg_we && (reg_addr == 2'd1);
    assign mask_we   = reg_we && (reg_addr == 2'd2);

    always_comb begin
        unique case (reg_addr)
            2'd0:    reg_rdata = {{(STAT_W-1){1'b0}}, busy};
            2'd1:    reg_rdata = status;
            2'd2:    reg_rdata = mask;
            default: reg_rdata = '0;
        endcase
    end

    dma_desc_ram #(.WORDS(RAM_WORDS), .IDX_W(IDX_W)) u_ram (
        .clk     (clk),
        .a_we    (host_ram_we),
        .a_idx   (host_ram_idx),
        .a_wdata (host_ram_wdata),
        .a_rdata (host_ram_rdata),
        .b_we    (eng_we),
        .b_idx   (eng_idx),
        .b_wdata (eng_wdata),
        .b_rdata (eng_rdata)
    );

    dma_chain_ctrl #(
        .RAM_WORDS  (RAM_WORDS),
        .IDX_W      (IDX_W),
        .DESC_BASE  (DESC_BASE),
        .PARAM_WORD (PARAM_WORD)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_cmd),
        .busy      (busy),
        .ram_idx   (eng_idx),
        .ram_rdata (eng_rdata),
        .ram_we    (eng_we),
        .ram_wdata (eng_wdata),
        .copy_go   (copy_go),
        .copy_src  (copy_src),
        .copy_dst  (copy_dst),
        .copy_cnt  (copy_cnt),
        .copy_done (copy_done),
        .ev_buf    (ev_buf),
        .ev_chain  (ev_chain),
        .ev_empty  (ev_empty),
        .ev_err    (ev_err)
    );

    dma_copy_unit u_copy (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (copy_go),
        .src_addr  (copy_src),
        .dst_addr  (copy_dst),
        .byte_cnt  (copy_cnt),
        .done      (copy_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    dma_status_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_we     (clr_we),
        .clr_bits   (reg_wdata),
        .mask_we    (mask_we),
        .mask_wdata (reg_wdata),
        .ev_buf     (ev_buf),
        .ev_chain   (ev_chain),
        .ev_empty   (ev_empty),
        .ev_err     (ev_err),
        .status     (status),
        .mask       (mask),
        .irq        (irq)
    );

    // R12: no memory traffic outside a run
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req)
        else $error("memory request while idle");

endmodule

// File: tb/dma_chain_top_tb.sv
`timescale 1ns/1ps
module dma_chain_top_tb;

    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_ram_we = 1'b0;
    logic [IDX_W-1:0] host_ram_idx = '0;
    logic [31:0]      host_ram_wdata = '0;
    logic [31:0]      host_ram_rdata;
    logic             reg_we = 1'b0;
    logic [1:0]       reg_addr = '0;
    logic [3:0]       reg_wdata = '0;
    logic [3:0]       reg_rdata;
    logic             busy, irq, mem_req, mem_we;
    logic [31:0]      mem_addr, mem_wdata;
    logic [3:0]       mem_be;
    logic [31:0]      mem_rdata = '0;
    logic             mem_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int acc_cnt = 0;
    logic [3:0]  last_be = '0;
    logic [31:0] bmem    [256];
    logic [31:0] exp_mem [256];

    always #5 clk = ~clk;

    dma_chain_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_ram_we(host_ram_we), .host_ram_idx(host_ram_idx),
        .host_ram_wdata(host_ram_wdata), .host_ram_rdata(host_ram_rdata),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // memory model: acknowledges one cycle after a request, one cycle gap between
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            mem_ack = 1'b1;
            acc_cnt++;
            if (mem_we) begin
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) bmem[mem_addr[9:2]][8*l +: 8] = mem_wdata[8*l +: 8];
                last_be = mem_be;
            end else begin
                mem_rdata = bmem[mem_addr[9:2]];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic ram_wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        host_ram_we = 1'b1; host_ram_idx = IDX_W'(idx); host_ram_wdata = d;
        @(negedge clk);
        host_ram_we = 1'b0;
    endtask

    task automatic ram_rd(input int idx, output logic [31:0] d);
        @(negedge clk);
        host_ram_idx = IDX_W'(idx);
        #1 d = host_ram_rdata;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [3:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input int slot, input logic [15:0] ctrl, input logic [31:0] cnt,
                            input logic [31:0] src, input logic [31:0] dst);
        ram_wr(slot*4 + 0, {ctrl, 8'hA5, 8'h5A});
        ram_wr(slot*4 + 1, cnt);
        ram_wr(slot*4 + 2, src);
        ram_wr(slot*4 + 3, dst);
    endtask

    task automatic set_first(input logic [15:0] addr);
        ram_wr(60, {addr, 16'h0000});
    endtask

    task automatic run_once();
        reg_wr(2'd0, 4'h1);
        for (int t = 0; t < 5000 && busy; t++) @(negedge clk);
    endtask

    task automatic expect_copy(input int src, input int dst, input int cnt);
        for (int j = 0; j < cnt; j++) begin
            int sa, da;
            sa = src + j; da = dst + j;
            exp_mem[da >> 2][8*(3 - (da % 4)) +: 8] = exp_mem[sa >> 2][8*(3 - (sa % 4)) +: 8];
        end
    endtask

    function automatic int mem_diffs();
        int n = 0;
        for (int i = 0; i < 256; i++) if (bmem[i] !== exp_mem[i]) n++;
        return n;
    endfunction

    typedef struct packed {
        logic [15:0] cnt;
        logic [15:0] src;
        logic        ien;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'd8, 16'h0000, 1'b1},
        '{16'd5, 16'h0010, 1'b0},
        '{16'd6, 16'h0020, 1'b1},
        '{16'd7, 16'h0030, 1'b0},
        '{16'd4, 16'h0040, 1'b1},
        '{16'd0, 16'h0050, 1'b1}
    };

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [3:0]  rv;
        logic [31:0] wv;
        int          a0;

        for (int i = 0; i < 256; i++)
            bmem[i] = (i < 128) ? {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)} : 32'hEEEE_EEEE;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 32'd0);
        chk(irq == 1'b0, "R1", "irq after reset", 32'(irq), 32'd0);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'd0);
        reg_rd(2'd1, rv);
        chk(rv == 4'h0, "R1", "status after reset", 32'(rv), 32'd0);
        reg_rd(2'd2, rv);
        chk(rv == 4'h0, "R1", "mask after reset", 32'(rv), 32'd0);

        // table walk: R2 R3 R4 R6 R7 R8 on single-descriptor chains
        set_first(16'h0800);
        for (int k = 0; k < 6; k++) begin
            logic [15:0] ctl;
            logic [3:0]  exp_st, exp_be;
            int cnt, src, dst, exp_acc;
            cnt = int'(VECS[k].cnt); src = int'(VECS[k].src); dst = 32'h200 + k*32;
            ctl = 16'h8800 | (VECS[k].ien ? 16'h1000 : 16'h0000);
            put_desc(0, ctl, 32'(cnt), 32'(src), 32'(dst));
            exp_mem = bmem;
            expect_copy(src, dst, cnt);
            a0 = acc_cnt;
            run_once();
            exp_acc = 2 * ((cnt + 3) / 4);
            chk(mem_diffs() == 0, "R3", "destination contents mismatching words", 32'(mem_diffs()), 32'd0);
            chk(acc_cnt - a0 == exp_acc, (cnt == 0) ? "R4" : "R3", "access count",
                32'(acc_cnt - a0), 32'(exp_acc));
            if (cnt > 0) begin
                unique case (cnt % 4)
                    1: exp_be = 4'b1000;
                    2: exp_be = 4'b1100;
                    3: exp_be = 4'b1110;
                    default: exp_be = 4'b1111;
                endcase
                chk(last_be == exp_be, "R3", "final write lanes", 32'(last_be), 32'(exp_be));
            end
            exp_st = 4'b0010 | (VECS[k].ien ? 4'b0001 : 4'b0000);
            reg_rd(2'd1, rv);
            chk(rv == exp_st, "R7", "status after descriptor", 32'(rv), 32'(exp_st));
            ram_rd(0, wv);
            chk(wv == {ctl & 16'h7FFF, 8'hA5, 8'h5A}, "R6", "written-back word 0",
                wv, {ctl & 16'h7FFF, 8'hA5, 8'h5A});
            reg_wr(2'd1, 4'hF);
        end

        // R5: descriptor without valid flag
        put_desc(0, 16'h0800, 32'd8, 32'h0, 32'h300);
        a0 = acc_cnt;
        run_once();
        reg_rd(2'd1, rv);
        chk(rv == 4'h4, "R5", "status after empty descriptor", 32'(rv), 32'h4);
        chk(acc_cnt == a0, "R5", "accesses on empty descriptor", 32'(acc_cnt - a0), 32'd0);
        ram_rd(0, wv);
        chk(wv == {16'h0800, 8'hA5, 8'h5A}, "R5", "empty descriptor unchanged", wv, {16'h0800, 8'hA5, 8'h5A});

        // R9: address below window (status keeps bit 2 from before)
        set_first(16'h07F0);
        a0 = acc_cnt;
        run_once();
        reg_rd(2'd1, rv);
        chk(rv == 4'hC, "R9", "status after low address", 32'(rv), 32'hC);
        chk(acc_cnt == a0, "R9", "accesses on bad address", 32'(acc_cnt - a0), 32'd0);

        // R11: partial write-one-to-clear
        reg_wr(2'd1, 4'h4);
        reg_rd(2'd1, rv);
        chk(rv == 4'h8, "R11", "status after clearing bit 2", 32'(rv), 32'h8);

        // R9: address beyond last full slot, then misaligned
        set_first(16'h08F4);
        run_once();
        reg_rd(2'd1, rv);
        chk(rv == 4'h8, "R9", "status after high address", 32'(rv), 32'h8);
        reg_wr(2'd1, 4'hF);
        set_first(16'h0802);
        run_once();
        reg_rd(2'd1, rv);
        chk(rv == 4'h8, "R9", "status after misaligned address", 32'(rv), 32'h8);

        // R10: interrupt follows mask and status
        chk(irq == 1'b0, "R10", "irq with zero mask", 32'(irq), 32'd0);
        reg_wr(2'd2, 4'h8);
        chk(irq == 1'b1, "R10", "irq with matching mask", 32'(irq), 32'd1);
        reg_wr(2'd2, 4'h4);
        chk(irq == 1'b0, "R10", "irq with other mask", 32'(irq), 32'd0);
        reg_wr(2'd2, 4'h8);
        reg_wr(2'd1, 4'h8);
        chk(irq == 1'b0, "R10", "irq after status cleared", 32'(irq), 32'd0);
        reg_wr(2'd2, 4'h0);

        // R8: two-descriptor chain starting at slot 2, second at +16
        put_desc(2, 16'h8000, 32'd4, 32'h60, 32'h300);
        put_desc(3, 16'h9800, 32'd4, 32'h64, 32'h304);
        set_first(16'h0820);
        exp_mem = bmem;
        expect_copy(32'h60, 32'h300, 4);
        expect_copy(32'h64, 32'h304, 4);
        a0 = acc_cnt;
        run_once();
        chk(mem_diffs() == 0, "R8", "chain destination mismatching words", 32'(mem_diffs()), 32'd0);
        chk(acc_cnt - a0 == 4, "R8", "chain access count", 32'(acc_cnt - a0), 32'd4);
        reg_rd(2'd1, rv);
        chk(rv == 4'h3, "R8", "chain status", 32'(rv), 32'h3);
        ram_rd(8, wv);
        chk(wv[31:16] == 16'h0000, "R6", "first chain word 0", 32'(wv[31:16]), 32'h0);
        ram_rd(12, wv);
        chk(wv[31:16] == 16'h1800, "R6", "second chain word 0", 32'(wv[31:16]), 32'h1800);
        reg_wr(2'd1, 4'hF);

        // R12: start while busy is ignored
        put_desc(0, 16'h8800, 32'd8, 32'h70, 32'h380);
        set_first(16'h0800);
        a0 = acc_cnt;
        reg_wr(2'd0, 4'h1);
        chk(busy == 1'b1, "R12", "busy after start", 32'(busy), 32'd1);
        reg_wr(2'd0, 4'h1);
        for (int t = 0; t < 5000 && busy; t++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R12", "busy after run", 32'(busy), 32'd0);
        reg_rd(2'd1, rv);
        chk(rv == 4'h2, "R12", "status after ignored start", 32'(rv), 32'h2);
        chk(acc_cnt - a0 == 4, "R12", "accesses after ignored start", 32'(acc_cnt - a0), 32'd4);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule